// File: doc/BRIEF.md
# Flash Suspend/Resume Sequencer

This block sits between the command decoder of a serial NOR flash and its array engine. While a sector erase, block erase or page program is running, it watches the decoded opcode stream. A suspend opcode pauses the running operation. A resume opcode lets it continue. The block keeps one status bit for a held erase and one for a held program, and it tells the write-enable latch to clear whenever a suspend is taken.

Two timing windows pace the sequence. Both are converted from microseconds into clock cycles using the `CLK_HZ` parameter, rounding up. The first is a settling window after a suspend: the suspend-ready flag rises only when it ends, and every command that arrives during it is dropped. The second is a minimum spacing after a resume: a new suspend that arrives before this spacing has elapsed is refused. Shifting the opcode in (one line or four lines) and running the array operation are handled elsewhere; this block receives a full opcode with a one-cycle valid.

Top module: `flash_susp_seq`

## Requirements
- R1: After reset, `erase_susp`, `prog_susp`, `susp_ready`, `pause_stb`, `continue_stb` and `wel_clr_stb` are all 0.
- R2: A suspend opcode (0xB0) is accepted when `op_busy` is 1, `op_kind` is 1 (sector erase), 2 (block erase) or 3 (page program), and the block is not already suspending or suspended. In the cycle after the accepting edge, `pause_stb` and `wel_clr_stb` are each 1 for exactly one cycle. In that same cycle, `erase_susp` becomes 1 for kinds 1 and 2, and `prog_susp` becomes 1 for kind 3.
- R3: A suspend opcode that arrives while `op_busy` is 0, or while `op_kind` is 0 (no suspendable operation), is ignored. No strobe fires and no status bit changes.
- R4: `susp_ready` rises exactly SETTLE cycles after the edge that accepted the suspend, and not before. SETTLE is ceil(CLK_HZ × SETTLE_US / 1e6), which is 20 with CLK_HZ = 1 MHz and SETTLE_US = 20.
- R5: During the settling window, every opcode is ignored, including resume (0x30) and suspend. `susp_ready` still rises on time.
- R6: A resume opcode (0x30) that arrives while suspended and ready has these effects in the cycle after the accepting edge: `continue_stb` is 1 for exactly one cycle, `erase_susp`, `prog_susp` and `susp_ready` all become 0, and `wel_clr_stb` stays 0.
- R7: A resume opcode that arrives when nothing is suspended is ignored. `continue_stb` stays 0.
- R8: A suspend presented at the edge GAP−1 cycles after the resume-accepting edge is refused. The same suspend presented at the edge GAP cycles after it is accepted. GAP is ceil(CLK_HZ × GAP_US / 1e6), which is 1000 with CLK_HZ = 1 MHz and GAP_US = 1000.
- R9: Every opcode other than 0xB0 and 0x30 is ignored, both while an operation runs and while it is suspended. No strobe fires and no status bit changes.
- R10: A further suspend opcode that arrives while already suspended is ignored. No second `pause_stb` fires and the status bits are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle qualifier for `cmd_opcode` |
| cmd_opcode | input | 8 | Decoded command opcode |
| op_busy | input | 1 | Array operation in progress |
| op_kind | input | 2 | 0 none, 1 sector erase, 2 block erase, 3 page program |
| erase_susp | output | 1 | Erase held in suspend |
| prog_susp | output | 1 | Program held in suspend |
| susp_ready | output | 1 | Settling window has expired; other commands may follow |
| pause_stb | output | 1 | One-cycle pulse telling the array engine to pause |
| continue_stb | output | 1 | One-cycle pulse telling the array engine to continue |
| wel_clr_stb | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The assertions assume four things about the inputs:
- `cmd_valid` is a single-cycle pulse per opcode.
- `op_kind` is stable while `op_busy` is 1.
- The array engine does not finish an operation while it is held.
- Time is measured purely in clock cycles, so the cycle counters in the checker stand for the microsecond windows.

The stimulus respects these assumptions. It holds `op_busy` and `op_kind` fixed across each suspend/resume episode. It sends each opcode for exactly one cycle, driven on the falling edge. After every resume it waits out the full spacing before the next episode, except in the one test that deliberately probes the GAP−1 and GAP edges.

// File: rtl/flash_susp_pkg.sv
package flash_susp_pkg;

   typedef enum logic [1:0] {
      OPK_NONE       = 2'd0,
      OPK_SECT_ERASE = 2'd1,
      OPK_BLK_ERASE  = 2'd2,
      OPK_PAGE_PROG  = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_SETTLE = 2'd1,
      PH_HELD   = 2'd2
   } phase_e;

   localparam logic [7:0] OPC_SUSPEND = 8'hB0;
   localparam logic [7:0] OPC_RESUME  = 8'h30;

   // Converts microseconds to clock cycles, rounding up.
   function automatic longint unsigned us_to_cycles(input longint unsigned hz,
                                                    input longint unsigned us);
      return (hz * us + 64'd999_999) / 64'd1_000_000;
   endfunction

endpackage

// File: rtl/flash_susp_decode.sv
module flash_susp_decode
   import flash_susp_pkg::*;
#(
   parameter int OPC_W         = 8,
   parameter bit PROG_SUSPENDS = 1'b1
) (
   input  logic             cmd_valid,
   input  logic [OPC_W-1:0] cmd_opcode,
   input  logic             op_busy,
   input  logic [1:0]       op_kind,
   output logic             susp_req,
   output logic             resume_req,
   output logic             susp_is_erase
);

   logic kind_erase;
   logic kind_prog;
   logic kind_ok;

   assign kind_erase = (op_kind == OPK_SECT_ERASE) || (op_kind == OPK_BLK_ERASE);
   assign kind_prog  = (op_kind == OPK_PAGE_PROG);

   // The parameter decides whether a page program may be suspended.
   generate
      if (PROG_SUSPENDS) begin : g_prog_ok
         assign kind_ok = kind_erase || kind_prog;
      end else begin : g_erase_only
         assign kind_ok = kind_erase;
      end
   endgenerate

   assign susp_req      = cmd_valid && (cmd_opcode == OPC_W'(OPC_SUSPEND)) && op_busy && kind_ok;
   assign resume_req    = cmd_valid && (cmd_opcode == OPC_W'(OPC_RESUME));
   assign susp_is_erase = kind_erase;

endmodule

// File: rtl/flash_susp_timer.sv
module flash_susp_timer #(
   parameter int LOAD = 4,
   parameter int W    = (LOAD < 2) ? 1 : $clog2(LOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);

   // A window of zero cycles needs no counter.
   generate
      if (LOAD == 0) begin : g_none
         assign busy = 1'b0;
         assign last = 1'b0;
      end else begin : g_count
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (start) begin
               cnt <= W'(LOAD);
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign busy = (cnt != '0);
         assign last = (cnt == W'(1));
      end
   endgenerate

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
   import flash_susp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic susp_req,
   input  logic resume_req,
   input  logic susp_is_erase,
   input  logic settle_last,
   input  logic gap_busy,
   output logic settle_start,
   output logic gap_start,
   output logic erase_susp,
   output logic prog_susp,
   output logic susp_ready,
   output logic pause_stb,
   output logic continue_stb,
   output logic wel_clr_stb
);

   phase_e phase;
   logic   take_susp;
   logic   take_res;

   assign take_susp    = susp_req && (phase == PH_RUN) && !gap_busy;
   assign take_res     = resume_req && (phase == PH_HELD);
   assign settle_start = take_susp;
   assign gap_start    = take_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_RUN;
         erase_susp   <= 1'b0;
         prog_susp    <= 1'b0;
         susp_ready   <= 1'b0;
         pause_stb    <= 1'b0;
         continue_stb <= 1'b0;
         wel_clr_stb  <= 1'b0;
      end else begin
         pause_stb    <= take_susp;
         wel_clr_stb  <= take_susp;
         continue_stb <= take_res;
         unique case (phase)
            PH_RUN: begin
               if (take_susp) begin
                  phase      <= PH_SETTLE;
                  erase_susp <= susp_is_erase;
                  prog_susp  <= !susp_is_erase;
               end
            end
            PH_SETTLE: begin
               if (settle_last) begin
                  phase      <= PH_HELD;
                  susp_ready <= 1'b1;
               end
            end
            PH_HELD: begin
               if (take_res) begin
                  phase      <= PH_RUN;
                  erase_susp <= 1'b0;
                  prog_susp  <= 1'b0;
                  susp_ready <= 1'b0;
               end
            end
            default: phase <= PH_RUN;
         endcase
      end
   end

endmodule

// File: rtl/flash_susp_seq.sv
module flash_susp_seq
   import flash_susp_pkg::*;
#(
   parameter longint CLK_HZ        = 100_000_000,
   parameter int     SETTLE_US     = 20,
   parameter int     GAP_US        = 1000,
   parameter bit     PROG_SUSPENDS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_opcode,
   input  logic       op_busy,
   input  logic [1:0] op_kind,
   output logic       erase_susp,
   output logic       prog_susp,
   output logic       susp_ready,
   output logic       pause_stb,
   output logic       continue_stb,
   output logic       wel_clr_stb
);

   localparam int SETTLE_CYC = int'(us_to_cycles(CLK_HZ, SETTLE_US));
   localparam int GAP_CYC    = int'(us_to_cycles(CLK_HZ, GAP_US));

   generate
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("settling window must span at least two cycles");
      end
      if (GAP_CYC < 2) begin : g_bad_gap
         $error("resume spacing must span at least two cycles");
      end
   endgenerate

   logic susp_req, resume_req, susp_is_erase;
   logic settle_start, settle_busy, settle_last;
   logic gap_start, gap_busy, gap_last;

   flash_susp_decode #(
      .OPC_W        (8),
      .PROG_SUSPENDS(PROG_SUSPENDS)
   ) u_decode (
      .cmd_valid    (cmd_valid),
      .cmd_opcode   (cmd_opcode),
      .op_busy      (op_busy),
      .op_kind      (op_kind),
      .susp_req     (susp_req),
      .resume_req   (resume_req),
      .susp_is_erase(susp_is_erase)
   );

   // Loaded with the full count: ready rises SETTLE_CYC edges after the accept.
   flash_susp_timer #(.LOAD(SETTLE_CYC)) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .start(settle_start),
      .busy (settle_busy),
      .last (settle_last)
   );

   // Loaded one short: suspend reopens exactly GAP_CYC edges after the resume.
   flash_susp_timer #(.LOAD(GAP_CYC - 1)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .start(gap_start),
      .busy (gap_busy),
      .last (gap_last)
   );

   flash_susp_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .susp_req     (susp_req),
      .resume_req   (resume_req),
      .susp_is_erase(susp_is_erase),
      .settle_last  (settle_last),
      .gap_busy     (gap_busy),
      .settle_start (settle_start),
      .gap_start    (gap_start),
      .erase_susp   (erase_susp),
      .prog_susp    (prog_susp),
      .susp_ready   (susp_ready),
      .pause_stb    (pause_stb),
      .continue_stb (continue_stb),
      .wel_clr_stb  (wel_clr_stb)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, settle_busy, gap_last};

endmodule

// File: rtl/flash_susp_checker.sv
module flash_susp_checker
   import flash_susp_pkg::*;
#(
   parameter longint CLK_HZ    = 100_000_000,
   parameter int     SETTLE_US = 20,
   parameter int     GAP_US    = 1000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_opcode,
   input logic       op_busy,
   input logic       erase_susp,
   input logic       prog_susp,
   input logic       susp_ready,
   input logic       pause_stb,
   input logic       continue_stb,
   input logic       wel_clr_stb
);

   localparam int SETTLE_CYC = int'(us_to_cycles(CLK_HZ, SETTLE_US));
   localparam int GAP_CYC    = int'(us_to_cycles(CLK_HZ, GAP_US));
   localparam int SW         = $clog2(SETTLE_CYC + 2) + 1;
   localparam int GW         = $clog2(GAP_CYC + 2) + 1;

   logic [SW-1:0] since_pause;
   logic [GW-1:0] since_res;
   logic          res_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_pause <= '0;
         since_res   <= '0;
         res_seen    <= 1'b0;
      end else begin
         if (pause_stb) since_pause <= SW'(1);
         else if (since_pause != '0 && since_pause <= SW'(SETTLE_CYC)) since_pause <= since_pause + 1'b1;
         if (continue_stb) begin
            since_res <= GW'(1);
            res_seen  <= 1'b1;
         end else if (since_res != '0 && since_res < GW'(GAP_CYC)) begin
            since_res <= since_res + 1'b1;
         end
      end
   end

   assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_susp && prog_susp));

   assert_pause_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pause_stb |-> ((erase_susp || prog_susp) && !susp_ready));

   assert_wel_with_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr_stb |-> (erase_susp || prog_susp));

   assert_no_pause_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_opcode == OPC_SUSPEND && !op_busy) |=> !pause_stb);

   assert_ready_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(susp_ready) |-> (since_pause == SW'(SETTLE_CYC)));

   assert_ready_needs_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      susp_ready |-> (erase_susp || prog_susp));

   assert_continue_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      continue_stb |-> (!erase_susp && !prog_susp && !susp_ready && !wel_clr_stb));

   assert_resume_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_opcode == OPC_RESUME && !erase_susp && !prog_susp) |=> !continue_stb);

   assert_gap_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_stb && res_seen) |-> (since_res >= GW'(GAP_CYC)));

endmodule

bind flash_susp_seq flash_susp_checker #(
   .CLK_HZ   (CLK_HZ),
   .SETTLE_US(SETTLE_US),
   .GAP_US   (GAP_US)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_opcode  (cmd_opcode),
   .op_busy     (op_busy),
   .erase_susp  (erase_susp),
   .prog_susp   (prog_susp),
   .susp_ready  (susp_ready),
   .pause_stb   (pause_stb),
   .continue_stb(continue_stb),
   .wel_clr_stb (wel_clr_stb)
);

// File: tb/flash_susp_seq_test.sv
module flash_susp_seq_test;

   localparam longint HZ     = 1_000_000;
   localparam int     S_US   = 20;
   localparam int     G_US   = 1000;
   localparam int     SETTLE = int'((HZ * S_US + 999_999) / 1_000_000);
   localparam int     GAP    = int'((HZ * G_US + 999_999) / 1_000_000);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_opcode = 8'h00;
   logic       op_busy = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic       erase_susp, prog_susp, susp_ready, pause_stb, continue_stb, wel_clr_stb;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   flash_susp_seq #(.CLK_HZ(HZ), .SETTLE_US(S_US), .GAP_US(G_US)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
      .op_busy(op_busy), .op_kind(op_kind), .erase_susp(erase_susp),
      .prog_susp(prog_susp), .susp_ready(susp_ready), .pause_stb(pause_stb),
      .continue_stb(continue_stb), .wel_clr_stb(wel_clr_stb)
   );

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (esb psb rdy pause cont wel)", req, act, exp);
      end
   endtask

   function automatic logic [5:0] outs();
      return {erase_susp, prog_susp, susp_ready, pause_stb, continue_stb, wel_clr_stb};
   endfunction

   // Called at a falling edge; the opcode is sampled at the next rising edge.
   task automatic send(input logic [7:0] c);
      cmd_valid  = 1'b1;
      cmd_opcode = c;
      @(negedge clk);
      cmd_valid  = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R1 reset", outs(), 6'b000000);

      // Sweep every busy/kind combination.
      for (int b = 0; b < 2; b++) begin
         for (int k = 0; k < 4; k++) begin
            logic [5:0] held;
            op_busy = b[0];
            op_kind = k[1:0];
            send(8'hB0);
            if (b == 0 || k == 0) begin
               check("R3 suspend ignored", outs(), 6'b000000);
            end else begin
               held = (k == 3) ? 6'b010000 : 6'b100000;
               check("R2 suspend accepted", outs(), held | 6'b000101);
               idle(4);
               send(8'h30);
               check("R5 resume in settle ignored", outs(), held);
               send(8'hB0);
               check("R5 suspend in settle ignored", outs(), held);
               idle(SETTLE - 7);
               check("R4 not ready early", outs(), held);
               idle(1);
               check("R4 ready on time", outs(), held | 6'b001000);
               send(8'hB0);
               check("R10 second suspend ignored", outs(), held | 6'b001000);
               send(8'h30);
               check("R6 resume pulse", outs(), 6'b000010);
               idle(1);
               check("R6 continue one cycle", outs(), 6'b000000);
               idle(GAP);
            end
         end
      end

      op_busy = 1'b1;
      op_kind = 2'd1;
      send(8'h30);
      check("R7 resume while idle", outs(), 6'b000000);

      // Other opcodes, both while running and while suspended.
      for (int c = 0; c < 256; c++) begin
         if (c != 8'hB0 && c != 8'h30) begin
            send(8'(c));
            check("R9 other opcode running", outs(), 6'b000000);
         end
      end
      send(8'hB0);
      idle(SETTLE);
      check("R4 ready before sweep", outs(), 6'b101000);
      for (int c = 0; c < 256; c++) begin
         if (c != 8'hB0 && c != 8'h30) begin
            send(8'(c));
            check("R9 other opcode held", outs(), 6'b101000);
         end
      end

      // Resume spacing edges.
      send(8'h30);
      check("R6 resume before gap probe", outs(), 6'b000010);
      idle(GAP - 2);
      send(8'hB0);
      check("R8 suspend at GAP-1 refused", outs(), 6'b000000);
      send(8'hB0);
      check("R8 suspend at GAP accepted", outs(), 6'b100101);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule